// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Register

This block is the digital front end of an 8-bit analog-to-digital converter inside a small microcontroller. Software sees two byte registers on a synchronous single-cycle bus: a control/status byte at offset 0x3C and a result byte at offset 0x3D. On the converter side the block issues a one-cycle start strobe with a 5-bit channel number. It then accepts a one-cycle done strobe together with an 8-bit sample.

Writing the control byte picks a channel and a mode, and it restarts the converter. In single mode one conversion completes per control write. In continuous mode the block restarts the converter after every completion. A completion flag and an optional interrupt request report finished conversions. The flag is a read-only status bit while interrupts are off, and it becomes a software-cleared interrupt flag while interrupts are on. Both the flag and the request are cleared as side effects of bus accesses. The all-ones channel code switches the converter off.

Top module: `adc_seq`

## Requirements
- R1: After reset the control byte reads 0x1F (flag, interrupt enable and continuous bit 0, channel bits all 1), the result byte reads 0x00, and irqReq and convStart are 0.
- R2: The control byte holds the completion flag in bit 7, the interrupt enable in bit 6, the continuous bit in bit 5 and the channel in bits 4..0. Writing it with a channel other than 0x1F raises convStart for exactly the one cycle that follows the write, with convChannel equal to the written channel. Bits 6..0 read back as written.
- R3: A control write with channel 0x1F starts no conversion. A later done strobe is ignored: the result byte and the flag stay unchanged.
- R4: A done strobe accepted during a conversion loads convSample into the result byte. The new value is readable from the next cycle.
- R5: In single mode with interrupts off, an accepted done sets the flag. No new start follows, and further done strobes are ignored until the next control write.
- R6: With interrupts off, the flag clears on any control write and on any read of the result byte.
- R7: In continuous mode a new convStart follows every accepted done by one cycle, and the result byte is updated each time. With interrupts off, the flag is set only by the first completion after a control write.
- R8: With interrupts on, every accepted done sets the flag and raises irqReq in the next cycle, in both single and continuous mode.
- R9: irqReq clears after a result read or a control write. With interrupts on, a result read leaves the flag set, and a control write loads the flag from write-data bit 7.
- R10: If a done strobe is accepted in the same cycle as a clearing access, the flag and irqReq end up set.
- R11: A control write while a conversion is running abandons it and starts a new one on the newly written channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register offset |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable, the only trigger for read side effects |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from addressed register |
| convStart | output | 1 | One-cycle conversion start strobe |
| convChannel | output | 5 | Selected channel |
| convDone | input | 1 | One-cycle conversion finished strobe |
| convSample | input | 8 | Sample valid with convDone |
| irqReq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a read is checked in the same cycle it is driven, and its side effect is checked on a read in the following cycle. convStart, irqReq and the flag all come out of a single register stage. Each is therefore expected exactly one cycle after the control write or done strobe that causes it. The bench drives each stimulus shortly after a falling edge and queues its expected values against that cycle. The monitor compares them a little later in the same low phase, so every sample falls between the edge that produced the value and the next one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ctrlWrite;
    logic dataRead;
    logic doneAccept;
  } seqStrobes_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h3C,
  parameter logic [AW-1:0] DATA_ADDR = 8'h3D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic [CW-1:0] wrChannel,
  input  logic          contMode,
  input  logic          convDone,
  output seqStrobes_t   strb,
  output logic          convStart
);
  localparam logic [CW-1:0] OFF_CODE = {CW{1'b1}};

  logic busy;
  logic launch;
  logic rearm;

  always_comb begin
    strb.ctrlWrite  = busWe && (busAddr == CTRL_ADDR);
    strb.dataRead   = busRe && (busAddr == DATA_ADDR);
    strb.doneAccept = convDone && busy;
    launch = strb.ctrlWrite && (wrChannel != OFF_CODE);
    rearm  = strb.doneAccept && contMode && !strb.ctrlWrite;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      if (strb.ctrlWrite)
        busy <= launch;             // a write aborts and maybe restarts
      else if (strb.doneAccept && !contMode)
        busy <= 1'b0;
      convStart <= launch || rearm;
    end
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h3C,
  parameter logic [AW-1:0] DATA_ADDR = 8'h3D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seqStrobes_t     strb,
  input  logic [AW-1:0]   busAddr,
  input  logic            busRe,
  input  logic [DW-1:0]   busWdata,
  input  logic [DW-1:0]   convSample,
  output logic [DW-1:0]   busRdata,
  output logic            contMode,
  output logic [DW-4:0]   channel,
  output logic            irqReq
);
  localparam int CW      = DW - 3;
  localparam int FLAG_B  = DW - 1;
  localparam int IEN_B   = DW - 2;
  localparam int CONT_B  = DW - 3;

  logic          doneFlag;
  logic          intEn;
  logic          firstSeen;
  logic [DW-1:0] resultReg;
  logic          flagSet;

  // flag source: every completion with interrupts on, else first one only in continuous mode
  always_comb flagSet = strb.doneAccept && (intEn || !contMode || !firstSeen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneFlag  <= 1'b0;
      intEn     <= 1'b0;
      contMode  <= 1'b0;
      channel   <= {CW{1'b1}};
      firstSeen <= 1'b0;
      resultReg <= '0;
      irqReq    <= 1'b0;
    end else begin
      if (strb.ctrlWrite) begin
        intEn    <= busWdata[IEN_B];
        contMode <= busWdata[CONT_B];
        channel  <= busWdata[CW-1:0];
      end

      if (strb.doneAccept)
        resultReg <= convSample;

      if (strb.ctrlWrite)
        firstSeen <= 1'b0;
      else if (strb.doneAccept)
        firstSeen <= 1'b1;

      if (flagSet)
        doneFlag <= 1'b1;
      else if (strb.ctrlWrite)
        doneFlag <= busWdata[IEN_B] & busWdata[FLAG_B];
      else if (strb.dataRead && !intEn)
        doneFlag <= 1'b0;

      if (strb.doneAccept && intEn)
        irqReq <= 1'b1;
      else if (strb.ctrlWrite || strb.dataRead)
        irqReq <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      if (busAddr == CTRL_ADDR)
        busRdata = {doneFlag, intEn, contMode, channel};
      else if (busAddr == DATA_ADDR)
        busRdata = resultReg;
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          convStart,
  output logic [DW-4:0] convChannel,
  input  logic          convDone,
  input  logic [DW-1:0] convSample,
  output logic          irqReq
);
  localparam int CW = DW - 3;
  localparam logic [AW-1:0] DATA_ADDR = CTRL_ADDR + 1'b1;

  seqStrobes_t strb;
  logic        contMode;

  adc_seq_ctrl #(.AW(AW), .CW(CW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .wrChannel(busWdata[CW-1:0]), .contMode(contMode), .convDone(convDone),
    .strb(strb), .convStart(convStart)
  );

  adc_seq_dp #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busAddr(busAddr), .busRe(busRe),
    .busWdata(busWdata), .convSample(convSample), .busRdata(busRdata),
    .contMode(contMode), .channel(convChannel), .irqReq(irqReq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h3C
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] busAddr,
  input logic          busWe,
  input logic          busRe,
  input logic [DW-1:0] busWdata,
  input logic          convStart,
  input logic [DW-4:0] convChannel,
  input logic          convDone,
  input logic          irqReq
);
  localparam logic [AW-1:0] DATA_ADDR = CTRL_ADDR + 1'b1;
  localparam logic [DW-4:0] OFF_CODE  = {(DW-3){1'b1}};

  logic ctrlWr;
  logic dataRd;
  assign ctrlWr = busWe && (busAddr == CTRL_ADDR);
  assign dataRd = busRe && (busAddr == DATA_ADDR);

  assert_start_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr && (busWdata[DW-4:0] != OFF_CODE) |=> convStart && (convChannel == $past(busWdata[DW-4:0])));

  assert_channel_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlWr |=> $stable(convChannel));

  assert_no_start_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlWr && (busWdata[DW-4:0] == OFF_CODE) |=> !convStart);

  assert_irq_from_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqReq) |-> $past(convDone));

  assert_irq_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlWr || dataRd) && !convDone |=> !irqReq);
endmodule

bind adc_seq adc_seq_chk #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .convStart(convStart), .convChannel(convChannel),
  .convDone(convDone), .irqReq(irqReq)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam time CLK_PERIOD = 10;
  localparam logic [7:0] CA = 8'h3C;
  localparam logic [7:0] DA = 8'h3D;
  localparam int K_RD = 0, K_IRQ = 1, K_START = 2, K_CHAN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic convStart;
  logic [4:0] convChannel;
  logic convDone = 1'b0;
  logic [7:0] convSample = '0;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .convStart(convStart),
    .convChannel(convChannel), .convDone(convDone), .convSample(convSample),
    .irqReq(irqReq)
  );

  // monitor: compares everything queued for the current cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.kind)
          K_RD:    act = busRdata;
          K_IRQ:   act = {7'd0, irqReq};
          K_START: act = {7'd0, convStart};
          default: act = {3'd0, convChannel};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver: one call per cycle, drives shortly after the falling edge
  task automatic cyc(input logic we, input logic re, input logic [7:0] a,
                     input logic [7:0] wd, input logic dn, input logic [7:0] s);
    @(negedge clk);
    #1;
    busWe = we; busRe = re; busAddr = a; busWdata = wd;
    convDone = dn; convSample = s;
  endtask

  task automatic expectV(input int k, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle();                      cyc(0, 0, 8'h00, 8'h00, 0, 8'h00); endtask
  task automatic wrCtrl(input logic [7:0] v); cyc(1, 0, CA, v, 0, 8'h00);       endtask
  task automatic doneCyc(input logic [7:0] s); cyc(0, 0, 8'h00, 8'h00, 1, s);  endtask
  task automatic rdChk(input logic [7:0] a, input logic [7:0] e, input string tag);
    cyc(0, 1, a, 8'h00, 0, 8'h00);
    expectV(K_RD, e, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdChk(CA, 8'h1F, "R1 ctrl reset");
    expectV(K_IRQ, 0, "R1 irq reset");
    expectV(K_START, 0, "R1 start reset");
    rdChk(DA, 8'h00, "R1 data reset");

    // R2 single, channel 3
    wrCtrl(8'h03);
    idle(); expectV(K_START, 1, "R2 start pulse"); expectV(K_CHAN, 8'h03, "R2 channel");
    idle(); expectV(K_START, 0, "R2 pulse one cycle");
    rdChk(CA, 8'h03, "R2 readback");

    // R4 R5 completion, R6 clear by data read
    doneCyc(8'hA5);
    rdChk(CA, 8'h83, "R5 flag set"); expectV(K_START, 0, "R5 no restart");
    rdChk(DA, 8'hA5, "R4 result loaded");
    rdChk(CA, 8'h03, "R6 cleared by data read");
    doneCyc(8'h11);
    rdChk(DA, 8'hA5, "R5 extra done ignored");
    rdChk(CA, 8'h03, "R5 flag stays clear");

    // R6 clear by write, R3 channel off
    wrCtrl(8'h02);
    doneCyc(8'h22);
    rdChk(CA, 8'h82, "R5 flag set ch2");
    wrCtrl(8'h1F);
    idle(); expectV(K_START, 0, "R3 no start when off");
    rdChk(CA, 8'h1F, "R6 cleared by ctrl write");
    doneCyc(8'h33);
    rdChk(DA, 8'h22, "R3 done ignored when off");
    rdChk(CA, 8'h1F, "R3 flag unchanged");

    // R7 continuous, interrupts off
    wrCtrl(8'h25);
    idle(); expectV(K_START, 1, "R7 first start");
    doneCyc(8'h40);
    rdChk(CA, 8'hA5, "R7 flag after first"); expectV(K_START, 1, "R7 restart 1");
    rdChk(DA, 8'h40, "R7 result 1");
    doneCyc(8'h41);
    rdChk(CA, 8'h25, "R7 flag not set again"); expectV(K_START, 1, "R7 restart 2");
    rdChk(DA, 8'h41, "R7 result 2");

    // R11 abort with new channel
    wrCtrl(8'h27);
    idle(); expectV(K_START, 1, "R11 restart"); expectV(K_CHAN, 8'h07, "R11 new channel");
    rdChk(CA, 8'h27, "R11 readback");
    doneCyc(8'h50);
    rdChk(CA, 8'hA7, "R7 first after rewrite");

    // R8 R9 interrupts on, single
    wrCtrl(8'h44);
    rdChk(CA, 8'h44, "R9 flag loaded 0");
    doneCyc(8'h60);
    rdChk(CA, 8'hC4, "R8 flag set"); expectV(K_IRQ, 1, "R8 irq raised");
    wrCtrl(8'h44);
    rdChk(CA, 8'h44, "R9 write clears flag"); expectV(K_IRQ, 0, "R9 irq cleared by write");
    doneCyc(8'h61);
    idle(); expectV(K_IRQ, 1, "R8 irq again");
    rdChk(DA, 8'h61, "R4 result 61");
    rdChk(CA, 8'hC4, "R9 read keeps flag"); expectV(K_IRQ, 0, "R9 irq cleared by read");
    wrCtrl(8'hC4);
    rdChk(CA, 8'hC4, "R9 flag loaded 1"); expectV(K_IRQ, 0, "R9 irq stays low");
    wrCtrl(8'h44);
    rdChk(CA, 8'h44, "R9 flag written 0");

    // R8 continuous with interrupts
    wrCtrl(8'h68);
    doneCyc(8'h70);
    idle(); expectV(K_IRQ, 1, "R8 cont irq 1"); expectV(K_START, 1, "R7 cont restart");
    rdChk(DA, 8'h70, "R8 result 70");
    idle(); expectV(K_IRQ, 0, "R9 cleared before next");
    doneCyc(8'h71);
    idle(); expectV(K_IRQ, 1, "R8 cont irq 2");

    // R10 same-cycle done and clearing read
    cyc(0, 1, DA, 8'h00, 1, 8'h72); expectV(K_RD, 8'h71, "R10 read old value");
    rdChk(CA, 8'hE8, "R10 flag kept"); expectV(K_IRQ, 1, "R10 irq kept");
    rdChk(DA, 8'h72, "R10 new result");
    wrCtrl(8'h09);
    cyc(0, 1, DA, 8'h00, 1, 8'h73); expectV(K_RD, 8'h72, "R10 read old value off");
    rdChk(CA, 8'h89, "R10 flag kept with irq off");

    idle(); idle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule